// File: doc/BRIEF.md
# Video Sync Generator with Master and Slave Modes

This block produces or follows horizontal and vertical video synchronisation. Software sets it up through three small registers: a 5-bit control word, a lines-per-frame count and a half-line period in clock cycles. In master mode the block runs its own pixel and half-line counters. From them it drives an H output and a V output, and it raises output enables for both pins. The V pin carries either a plain vertical sync or a composite signal. The composite signal is built from equalizing pulses, a serrated vertical interval and the ordinary H sync.

Timing is interlaced or progressive. Interlace is used only when it is requested and the line count is odd. Each interlaced field is then one line count of half-lines long, so every second field begins at mid-line and a field flag toggles. In slave mode the pins are inputs. The pixel counter restarts on each active H edge and the line position is cleared by each active V edge. The polarity of each pin is set separately in both modes. Downstream display logic reads the counter outputs as the current raster position.

Top module: `video_sync_gen`

## Requirements
- R1: After reset the control word reads 0x0000, the line-count register reads DEF_LINES and the half-line register reads DEF_HALF. Both output enables are 0, and hOut and vOut are 0 whenever the block is in slave mode.
- R2: Control bit 0 set selects master mode and raises hOe and vOe. linePos counts 0 to 2*HP-1 and wraps, where HP is the half-line register. hOut is active while linePos < HSYNC_PIX (default 8).
- R3: A control write that moves bit 0 from 0 to 1 clears linePos, halfIdx and fieldOdd at that clock edge, and counting resumes from there.
- R4: Progressive timing applies when control bit 2 is 1 or the line count NL is even. A field is then 2*NL half-lines, fieldOdd stays 0, and with control bit 1 at 0 vOut is active during half-lines EQ_HALVES to 2*EQ_HALVES-1 of the field (EQ_HALVES defaults to 6).
- R5: Interlaced timing applies when control bit 2 is 0 and NL is odd. A field is then NL half-lines, so alternate fields start at mid-line, and fieldOdd toggles at every field end.
- R6: With control bit 1 at 1 in master mode, vOut is composite. During half-lines [0,EQ_HALVES) and [2*EQ_HALVES,3*EQ_HALVES) it is active for the first EQ_PIX (default 4) cycles of each half-line. During [EQ_HALVES,2*EQ_HALVES) it is active except for the last SERR_PIX (default 7) cycles of each half-line. Elsewhere it equals the H sync.
- R7: Control bit 3 inverts vOut and control bit 4 inverts hOut in master mode.
- R8: In slave mode the active edge of a pin is the rising edge of the pin XOR its polarity bit (bit 4 for hIn, bit 3 for vIn).
- R9: In slave mode, an active hIn edge makes linePos 0 one cycle later and adds 2 to halfIdx. Without an edge, linePos rises by 1 each cycle and saturates at its maximum.
- R10: In slave mode an active vIn edge makes halfIdx 0 one cycle later without touching linePos. When H and V edges fall in the same cycle, halfIdx becomes 0 and linePos becomes 0.
- R11: In slave mode the line-count and half-line registers have no effect: linePos counts past 2*HP without wrapping.
- R12: The register map is: address 0 is the control word (bits 4..0 stored, the other bits read 0), address 1 is the line count (LINE_W bits), address 2 is the half-line period (PIX_W bits), and address 3 reads 0. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| hIn | input | 1 | H sync pin input (slave) |
| vIn | input | 1 | V sync pin input (slave) |
| hOut | output | 1 | H sync pin output (master) |
| vOut | output | 1 | V or composite sync pin output (master) |
| hOe | output | 1 | H pin output enable |
| vOe | output | 1 | V pin output enable |
| linePos | output | PIX_W+1 | Pixel position within the line |
| halfIdx | output | LINE_W+1 | Half-line index within the field |
| fieldOdd | output | 1 | Field flag, toggles in interlaced timing |

## Verification
In slave mode an H edge and a V edge can act on halfIdx in the same cycle: one asks for +2 and the other asks for 0. The bench pulses hIn and vIn on the same clock and expects halfIdx 0 together with linePos 0. It also pulses each pin alone and expects +2 or 0 respectively, so the priority is judged against both single-pin outcomes. In master mode a half-line step and a field end coincide at every field boundary. The bench computes the expected raster from elapsed cycles, which judges whether halfIdx wraps to 0 rather than stepping on, and whether fieldOdd toggles in that same cycle.

// File: rtl/sync_pkg.sv
package sync_pkg;

  // Control word, bit 4 down to bit 0.
  typedef struct packed {
    logic hPol;    // bit 4: invert H pin
    logic vPol;    // bit 3: invert V pin
    logic prog;    // bit 2: force progressive timing
    logic comp;    // bit 1: composite sync on V pin
    logic master;  // bit 0: drive pins from internal counters
  } ctrl_t;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic clr;         // entering master mode: clear counters
    logic pixWrap;     // master: last pixel of the line
    logic halfStep;    // master: last pixel of a half-line
    logic fieldWrap;   // master: last pixel of the field
    logic interlaced;  // master: effective interlace
    logic hEdge;       // slave: active H input edge
    logic vEdge;       // slave: active V input edge
  } strobe_t;

endpackage

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import sync_pkg::*;
#(
  parameter int PIX_W     = 11,
  parameter int LINE_W    = 11,
  parameter int DEF_LINES = 525,
  parameter int DEF_HALF  = 858
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              hIn,
  input  logic              vIn,
  input  logic [PIX_W:0]    pixCnt,
  input  logic [LINE_W:0]   halfCnt,
  output ctrl_t             ctrl,
  output logic [PIX_W-1:0]  halfReg,
  output strobe_t           strb
);

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LINES = 2'd1;
  localparam logic [1:0] ADDR_HALF  = 2'd2;

  logic [LINE_W-1:0] linesReg;
  logic              hPrev, vPrev;
  logic              hAct, vAct;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[15:5];

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      linesReg <= LINE_W'(DEF_LINES);
      halfReg  <= PIX_W'(DEF_HALF);
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL:  ctrl     <= ctrl_t'(regWdata[4:0]);
        ADDR_LINES: linesReg <= regWdata[LINE_W-1:0];
        ADDR_HALF:  halfReg  <= regWdata[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdata = {11'd0, ctrl};
      ADDR_LINES: regRdata = 16'(linesReg);
      ADDR_HALF:  regRdata = 16'(halfReg);
      default:    regRdata = '0;
    endcase
  end

  // Slave pin edge detection after polarity correction
  assign hAct = hIn ^ ctrl.hPol;
  assign vAct = vIn ^ ctrl.vPol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= hAct;
      vPrev <= vAct;
    end
  end

  // Master raster boundaries
  logic [PIX_W+1:0]  pixNext, lineLen, halfLen;
  logic [LINE_W+1:0] halfNext, fieldLen;
  logic              intlc, lineEnd, midLine, fieldEnd;

  always_comb begin
    pixNext  = {1'b0, pixCnt} + (PIX_W+2)'(1);
    lineLen  = {1'b0, halfReg, 1'b0};
    halfLen  = {2'b0, halfReg};
    lineEnd  = pixNext >= lineLen;
    midLine  = pixNext == halfLen;
    intlc    = ~ctrl.prog & linesReg[0];
    halfNext = {1'b0, halfCnt} + (LINE_W+2)'(1);
    fieldLen = intlc ? {2'b0, linesReg} : {1'b0, linesReg, 1'b0};
    fieldEnd = halfNext >= fieldLen;
  end

  always_comb begin
    strb            = '0;
    strb.clr        = regWe && (regAddr == ADDR_CTRL) && regWdata[0] && !ctrl.master;
    strb.interlaced = ctrl.master & intlc;
    if (ctrl.master) begin
      strb.pixWrap   = lineEnd;
      strb.halfStep  = lineEnd | midLine;
      strb.fieldWrap = (lineEnd | midLine) & fieldEnd;
    end else begin
      strb.hEdge = hAct & ~hPrev;
      strb.vEdge = vAct & ~vPrev;
    end
  end

  // R3: a clear strobe always lands the control word in master mode
  p_clear_enters_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> ctrl.master);

endmodule

// File: rtl/sync_datapath.sv
module sync_datapath
  import sync_pkg::*;
#(
  parameter int PIX_W     = 11,
  parameter int LINE_W    = 11,
  parameter int EQ_HALVES = 6,
  parameter int HSYNC_PIX = 8,
  parameter int EQ_PIX    = 4,
  parameter int SERR_PIX  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  ctrl_t             ctrl,
  input  logic [PIX_W-1:0]  halfReg,
  output logic [PIX_W:0]    pixCnt,
  output logic [LINE_W:0]   halfCnt,
  output logic              fieldOdd,
  output logic              hOut,
  output logic              vOut
);

  localparam logic [PIX_W:0]   PIX_MAX  = '1;
  localparam logic [LINE_W:0]  HALF_MAX = '1;
  localparam logic [LINE_W:0]  EQ_A     = (LINE_W+1)'(EQ_HALVES);
  localparam logic [LINE_W:0]  EQ_B     = (LINE_W+1)'(2 * EQ_HALVES);
  localparam logic [LINE_W:0]  EQ_C     = (LINE_W+1)'(3 * EQ_HALVES);
  localparam logic [PIX_W:0]   HS_LEN   = (PIX_W+1)'(HSYNC_PIX);
  localparam logic [PIX_W:0]   EQ_LEN   = (PIX_W+1)'(EQ_PIX);
  localparam logic [PIX_W+1:0] SERR_LEN = (PIX_W+2)'(SERR_PIX);

  logic unusedCtrl;
  assign unusedCtrl = ctrl.prog;

  // Counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixCnt   <= '0;
      halfCnt  <= '0;
      fieldOdd <= 1'b0;
    end else if (strb.clr) begin
      pixCnt   <= '0;
      halfCnt  <= '0;
      fieldOdd <= 1'b0;
    end else if (ctrl.master) begin
      pixCnt <= strb.pixWrap ? '0 : pixCnt + 1'b1;
      if (strb.halfStep)
        halfCnt <= strb.fieldWrap ? '0 : halfCnt + 1'b1;
      if (strb.fieldWrap)
        fieldOdd <= strb.interlaced ? ~fieldOdd : 1'b0;
    end else begin
      if (strb.hEdge)
        pixCnt <= '0;
      else if (pixCnt != PIX_MAX)
        pixCnt <= pixCnt + 1'b1;
      if (strb.vEdge)
        halfCnt <= '0;
      else if (strb.hEdge)
        halfCnt <= (halfCnt >= HALF_MAX - 1'b1) ? HALF_MAX : halfCnt + 2'd2;
    end
  end

  // Sync shaping
  logic [PIX_W:0] hpW, subCnt;
  logic hSync, inPre, inVert, inPost, eqPulse, broad, vComp, vSel;

  always_comb begin
    hpW     = {1'b0, halfReg};
    subCnt  = (pixCnt >= hpW) ? pixCnt - hpW : pixCnt;
    hSync   = pixCnt < HS_LEN;
    inPre   = halfCnt < EQ_A;
    inVert  = (halfCnt >= EQ_A) && (halfCnt < EQ_B);
    inPost  = (halfCnt >= EQ_B) && (halfCnt < EQ_C);
    eqPulse = subCnt < EQ_LEN;
    broad   = ({1'b0, subCnt} + SERR_LEN) < {1'b0, hpW};
    if (inPre || inPost)  vComp = eqPulse;
    else if (inVert)      vComp = broad;
    else                  vComp = hSync;
    vSel = ctrl.comp ? vComp : inVert;
    hOut = ctrl.master & (hSync ^ ctrl.hPol);
    vOut = ctrl.master & (vSel ^ ctrl.vPol);
  end

  // R3: entering master mode restarts the raster
  p_clear_counters_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> (pixCnt == '0) && (halfCnt == '0) && !fieldOdd);

  // R10: V edge wins over H edge
  p_vedge_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.vEdge && !strb.clr) |=> (halfCnt == '0));

  // R9: lone H edge advances by one line
  p_hedge_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hEdge && !strb.vEdge && !strb.clr && (halfCnt < HALF_MAX - 2'd2))
      |=> (halfCnt == $past(halfCnt) + 2'd2) && (pixCnt == '0));

  // R5: field flag toggles at each interlaced field end
  p_field_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fieldWrap && strb.interlaced) |=> (fieldOdd != $past(fieldOdd)));

  // R4: progressive timing keeps the field flag low
  p_field_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fieldWrap && !strb.interlaced) |=> !fieldOdd);

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import sync_pkg::*;
#(
  parameter int PIX_W     = 11,
  parameter int LINE_W    = 11,
  parameter int DEF_LINES = 525,
  parameter int DEF_HALF  = 858,
  parameter int EQ_HALVES = 6,
  parameter int HSYNC_PIX = 8,
  parameter int EQ_PIX    = 4,
  parameter int SERR_PIX  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic [15:0]     regWdata,
  output logic [15:0]     regRdata,
  input  logic            hIn,
  input  logic            vIn,
  output logic            hOut,
  output logic            vOut,
  output logic            hOe,
  output logic            vOe,
  output logic [PIX_W:0]  linePos,
  output logic [LINE_W:0] halfIdx,
  output logic            fieldOdd
);

  ctrl_t            ctrl;
  strobe_t          strb;
  logic [PIX_W-1:0] halfReg;

  sync_ctrl #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .DEF_LINES(DEF_LINES), .DEF_HALF(DEF_HALF)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .hIn(hIn), .vIn(vIn),
    .pixCnt(linePos), .halfCnt(halfIdx),
    .ctrl(ctrl), .halfReg(halfReg), .strb(strb)
  );

  sync_datapath #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .EQ_HALVES(EQ_HALVES),
    .HSYNC_PIX(HSYNC_PIX), .EQ_PIX(EQ_PIX), .SERR_PIX(SERR_PIX)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .ctrl(ctrl), .halfReg(halfReg),
    .pixCnt(linePos), .halfCnt(halfIdx), .fieldOdd(fieldOdd),
    .hOut(hOut), .vOut(vOut)
  );

  assign hOe = ctrl.master;
  assign vOe = ctrl.master;

endmodule

// File: tb/tb_video_sync_gen.sv
`timescale 1ns/1ps
module tb_video_sync_gen;

  localparam int PIX_W = 11, LINE_W = 11;
  localparam int DEF_LINES = 525, DEF_HALF = 858;
  localparam int EQN = 6, HSW = 8, EQW = 4, SERW = 7;

  logic clk = 0, rst_n = 0;
  logic regWe = 0;
  logic [1:0] regAddr = 0;
  logic [15:0] regWdata = 0;
  logic [15:0] regRdata;
  logic hIn = 0, vIn = 0;
  logic hOut, vOut, hOe, vOe, fieldOdd;
  logic [PIX_W:0] linePos;
  logic [LINE_W:0] halfIdx;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  video_sync_gen #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .DEF_LINES(DEF_LINES), .DEF_HALF(DEF_HALF),
    .EQ_HALVES(EQN), .HSYNC_PIX(HSW), .EQ_PIX(EQW), .SERR_PIX(SERW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hIn(hIn), .vIn(vIn),
    .hOut(hOut), .vOut(vOut), .hOe(hOe), .vOe(vOe),
    .linePos(linePos), .halfIdx(halfIdx), .fieldOdd(fieldOdd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWe = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = int'(regRdata);
  endtask

  // Expected master V output from the requirements
  function automatic bit expV(input int h, input int sub, input int pix, input int hp, input bit comp);
    bit hs = pix < HSW;
    bit vert = (h >= EQN) && (h < 2*EQN);
    if (!comp) return vert;
    if (h < EQN || (h >= 2*EQN && h < 3*EQN)) return sub < EQW;
    if (vert) return (sub + SERW) < hp;
    return hs;
  endfunction

  task automatic runMaster(input int hp, input int nl, input logic [4:0] bits);
    bit intl = !bits[2] && nl[0];
    int len = intl ? 2*nl*hp + 3*hp : 4*nl*hp + 3*hp;
    regWrite(2'd0, 16'd0);            // back to slave
    regWrite(2'd1, 16'(nl));
    regWrite(2'd2, 16'(hp));
    regWrite(2'd0, {11'd0, bits | 5'd1});  // enter master: clear (R3)
    for (int t = 0; t < len; t++) begin
      int pix = t % (2*hp);
      int g = t / hp;
      int sub = t % hp;
      int h = intl ? g % nl : g % (2*nl);
      int fo = intl ? (g / nl) & 1 : 0;
      @(negedge clk);
      if (t == 0) begin
        chk("R3 linePos after entry", int'(linePos), 0);
        chk("R3 halfIdx after entry", int'(halfIdx), 0);
        chk("R2 output enables", int'({hOe, vOe}), 3);
      end
      chk("R2 linePos", int'(linePos), pix);
      chk(intl ? "R5 halfIdx" : "R4 halfIdx", int'(halfIdx), h);
      chk(intl ? "R5 fieldOdd" : "R4 fieldOdd", int'(fieldOdd), fo);
      chk("R2/R7 hOut", int'(hOut), int'((pix < HSW) ^ bits[4]));
      chk(bits[1] ? "R6/R7 vOut composite" : "R4/R7 vOut plain",
          int'(vOut), int'(expV(h, sub, pix, hp, bits[1]) ^ bits[3]));
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, prevHalf, prevPix;
    void'($urandom(32'd20240611));
    #20 rst_n = 1;

    // R1 reset state
    regRead(2'd0, v); chk("R1 control reset", v, 0);
    regRead(2'd1, v); chk("R1 lines reset", v, DEF_LINES);
    regRead(2'd2, v); chk("R1 half reset", v, DEF_HALF);
    chk("R1 oe in slave", int'({hOe, vOe}), 0);
    chk("R1 outputs quiet", int'({hOut, vOut}), 0);

    // R12 register map
    regWrite(2'd1, 16'd1234); regRead(2'd1, v); chk("R12 lines readback", v, 1234);
    regWrite(2'd2, 16'hF055); regRead(2'd2, v); chk("R12 half width", v, 16'h0055);
    regWrite(2'd0, 16'hFFE0); regRead(2'd0, v); chk("R12 control upper bits", v, 0);
    regRead(2'd3, v); chk("R12 unused address", v, 0);

    // R9 lone H edge
    repeat (3) @(negedge clk);
    prevHalf = int'(halfIdx);
    hIn = 1;
    @(negedge clk);
    chk("R9 linePos after H edge", int'(linePos), 0);
    chk("R9 halfIdx after H edge", int'(halfIdx), prevHalf + 2);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R9 linePos counting", int'(linePos), k);
    end
    chk("R9 no second edge while high", int'(halfIdx), prevHalf + 2);
    hIn = 0;
    repeat (2) @(negedge clk);
    hIn = 1; @(negedge clk); hIn = 0;
    chk("R9 second H edge", int'(halfIdx), prevHalf + 4);

    // R10 lone V edge keeps linePos
    repeat (2) @(negedge clk);
    prevPix = int'(linePos);
    vIn = 1;
    @(negedge clk);
    chk("R10 halfIdx after V edge", int'(halfIdx), 0);
    chk("R10 linePos untouched", int'(linePos), prevPix + 1);
    vIn = 0; hIn = 0;
    repeat (2) @(negedge clk);
    hIn = 1; @(negedge clk);
    hIn = 0; repeat (2) @(negedge clk);
    // R10 coincident H and V edges
    hIn = 1; vIn = 1;
    @(negedge clk);
    chk("R10 coincident halfIdx", int'(halfIdx), 0);
    chk("R10 coincident linePos", int'(linePos), 0);
    chk("R1 outputs quiet in slave", int'({hOut, vOut, hOe, vOe}), 0);

    // R8 inverted polarity: falling pin edge becomes active
    regWrite(2'd0, 16'h0018);
    repeat (2) @(negedge clk);
    prevHalf = int'(halfIdx);
    hIn = 0;
    @(negedge clk);
    chk("R8 inverted H edge linePos", int'(linePos), 0);
    chk("R8 inverted H edge halfIdx", int'(halfIdx), prevHalf + 2);
    prevPix = int'(linePos);
    hIn = 1;
    @(negedge clk);
    chk("R8 rising edge inactive", int'(linePos), prevPix + 1);
    vIn = 0;
    @(negedge clk);
    chk("R8 inverted V edge", int'(halfIdx), 0);
    chk("R1 outputs quiet with inverted polarity", int'({hOut, vOut}), 0);

    // R11 timing registers ignored in slave
    regWrite(2'd2, 16'd3);
    regWrite(2'd1, 16'd3);
    @(negedge clk);
    prevPix = int'(linePos);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R11 linePos ignores half register", int'(linePos), prevPix + k);
    end
    hIn = 1; vIn = 1;

    // Directed master cases
    runMaster(40, 31, 5'b00001);  // interlaced, plain V (R5, R4 window)
    runMaster(40, 31, 5'b00011);  // interlaced, composite (R6)
    runMaster(32, 30, 5'b00001);  // even count falls back to progressive (R4)
    runMaster(36, 25, 5'b11111);  // progressive forced, composite, inverted (R7)
    runMaster(24, 21, 5'b10011);  // smallest sizes, H inverted

    // Random master configurations
    for (int i = 0; i < 4; i++) begin
      int hp = 24 + int'($urandom % 25);
      int nl = 21 + int'($urandom % 15);
      logic [4:0] b = 5'($urandom % 32);
      runMaster(hp, nl, b);
    end

    regWrite(2'd0, 16'd0);
    @(negedge clk);
    chk("R1 enables drop on return to slave", int'({hOe, vOe, hOut, vOut}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule